// File: doc/BRIEF.md
# Vector Length Override Unit

This unit keeps a private vector length (VL) and maximum vector length (MAXVL) pair. It is separate from the main vector state. A 64-bit prefixed instruction carries a 12-bit length-control field, which the decoder hands to the unit together with a one-cycle `op_valid` strobe. The unit reads at most one scalar register, through the `src_idx`/`src_data` read port. It then updates its 12-bit override state word and can echo the resulting VL into a scalar register as a write-back request.

The field has four parts. Bit 11 is the mode bit. Bits 10:6 name the echo destination register. Bits 5:1 hold a 5-bit value, and bit 0 is the sub-mode bit. Together these select one of four actions: leave everything alone, load VL from an immediate, load VL from a register, or set MAXVL (setting VL with it, or clamping VL to it).

The unit accepts one field per strobe and never stalls, so it applies no back-pressure. The register file must take the write-back pulse in the cycle it appears, and the unit never holds it. All results appear one clock edge after the strobe.

Top module: `vl_override_unit`

## Requirements
- R1: After reset, VL is 1 and MAXVL is 1, and `wb_valid` and `illegal_op` are low.
- R2: A strobe with an all-zero field changes neither VL nor MAXVL and raises neither `wb_valid` nor `illegal_op`.
- R3: For a nonzero field with bit 11 = 0 and bit 0 = 0, VL becomes bits 5:1 plus one (so 0 gives VL = 1) and MAXVL is kept. VL is not limited by MAXVL in this mode.
- R4: For bit 11 = 0 and bit 0 = 1 with bits 5:1 equal to zero, `illegal_op` pulses for one cycle. VL and MAXVL are kept and no write-back is issued.
- R5: For bit 11 = 0 and bit 0 = 1 with bits 5:1 nonzero, VL becomes the full-width value on `src_data`, limited to the range 1 to MAXVL. `src_idx` always shows bits 5:1 of `vl_field` in the same cycle.
- R6: For bit 11 = 1 and bit 0 = 0, both MAXVL and VL become bits 5:1 plus one.
- R7: For bit 11 = 1 and bit 0 = 1, MAXVL becomes bits 5:1 plus one. VL is lowered to the new MAXVL only if it was larger, and is otherwise kept.
- R8: A strobe that updates state with bits 10:6 nonzero produces `wb_valid` with `wb_idx` equal to bits 10:6 and `wb_data` equal to the new VL, zero-extended. With bits 10:6 zero, there is no write-back.
- R9: `ovr_state` bits 11:6 hold VL and bits 5:0 hold MAXVL.
- R10: Updates are visible on the clock edge after the strobe. `wb_valid` and `illegal_op` are pulses tied to that strobe, and in a cycle after no strobe both are low and the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle strobe qualifying `vl_field` |
| vl_field | input | 12 | Length-control field from the prefix |
| src_idx | output | 5 | Scalar read-port index (bits 5:1 of the field) |
| src_data | input | XLEN | Value read from the scalar register `src_idx` |
| ovr_state | output | 12 | Override state word {VL, MAXVL} |
| wb_valid | output | 1 | Scalar write-back request pulse |
| wb_idx | output | 5 | Write-back destination register |
| wb_data | output | XLEN | Write-back data (new VL, zero-extended) |
| illegal_op | output | 1 | Illegal-instruction pulse |

## Verification
Some states cannot be reached without first setting up others. VL can be left above MAXVL only through the immediate-VL mode, and a later MAXVL-only set must be issued to see the clamp take effect. The register-sourced path also has a hard case: a source value whose low six bits look in range while its upper bits are set. The stimulus first drives these sequences in order, then runs a long random stream. A behavioural model tracks VL and MAXVL across that stream, and each cycle is compared against it.

// File: rtl/vlo_pkg.sv
package vlo_pkg;
  localparam int FIELD_W = 12;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 5;
  localparam int LEN_W   = 6;
  localparam logic [LEN_W-1:0] RST_VL    = 6'd1;
  localparam logic [LEN_W-1:0] RST_MAXVL = 6'd1;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_IMM_VL,
    OP_REG_VL,
    OP_SET_BOTH,
    OP_SET_MAX
  } vlo_op_e;

  typedef struct packed {
    vlo_op_e          op;
    logic [IDX_W-1:0] dest;
    logic [IMM_W-1:0] val;
  } vlo_dec_t;
endpackage

// File: rtl/vlo_decode.sv
module vlo_decode
  import vlo_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  output vlo_dec_t           dec,
  output logic               bad_src
);
  always_comb begin
    dec.dest = field[10:6];
    dec.val  = field[5:1];
    if (field == '0) begin
      dec.op = OP_NONE;
    end else begin
      unique case ({field[11], field[0]})
        2'b00:   dec.op = OP_IMM_VL;
        2'b01:   dec.op = OP_REG_VL;
        2'b10:   dec.op = OP_SET_BOTH;
        default: dec.op = OP_SET_MAX;
      endcase
    end
    bad_src = (dec.op == OP_REG_VL) && (dec.val == '0);
  end
endmodule

// File: rtl/vlo_clamp.sv
module vlo_clamp
  import vlo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]  src,
  input  logic [LEN_W-1:0] limit,
  output logic [LEN_W-1:0] vl
);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);
  logic [XLEN-1:0] limit_ext;

  always_comb begin
    limit_ext = XLEN'(limit);
    if (src == '0)             vl = LEN_W'(ONE);
    else if (src > limit_ext)  vl = limit;
    else                       vl = src[LEN_W-1:0];
  end
endmodule

// File: rtl/vlo_next.sv
module vlo_next
  import vlo_pkg::*;
(
  input  vlo_dec_t           dec,
  input  logic               bad_src,
  input  logic [LEN_W-1:0]   cur_vl,
  input  logic [LEN_W-1:0]   cur_max,
  input  logic [LEN_W-1:0]   reg_vl,
  output logic [LEN_W-1:0]   nxt_vl,
  output logic [LEN_W-1:0]   nxt_max,
  output logic               update
);
  logic [LEN_W-1:0] imm_p1;

  always_comb begin
    imm_p1  = LEN_W'(dec.val) + LEN_W'(1);
    nxt_vl  = cur_vl;
    nxt_max = cur_max;
    update  = 1'b0;
    unique case (dec.op)
      OP_IMM_VL: begin
        nxt_vl = imm_p1;
        update = 1'b1;
      end
      OP_REG_VL: begin
        if (!bad_src) begin
          nxt_vl = reg_vl;
          update = 1'b1;
        end
      end
      OP_SET_BOTH: begin
        nxt_vl  = imm_p1;
        nxt_max = imm_p1;
        update  = 1'b1;
      end
      OP_SET_MAX: begin
        nxt_max = imm_p1;
        nxt_vl  = (cur_vl > imm_p1) ? imm_p1 : cur_vl;
        update  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vl_override_unit.sv
module vl_override_unit
  import vlo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [FIELD_W-1:0]   vl_field,
  output logic [IDX_W-1:0]     src_idx,
  input  logic [XLEN-1:0]      src_data,
  output logic [2*LEN_W-1:0]   ovr_state,
  output logic                 wb_valid,
  output logic [IDX_W-1:0]     wb_idx,
  output logic [XLEN-1:0]      wb_data,
  output logic                 illegal_op
);
  vlo_dec_t         dec;
  logic             bad_src;
  logic [LEN_W-1:0] vl_q, max_q;
  logic [LEN_W-1:0] reg_vl, nxt_vl, nxt_max;
  logic             update;
  logic             wb_q, ill_q;
  logic [IDX_W-1:0] wb_idx_q;

  vlo_decode u_dec (
    .field   (vl_field),
    .dec     (dec),
    .bad_src (bad_src)
  );

  vlo_clamp #(.XLEN(XLEN)) u_clamp (
    .src   (src_data),
    .limit (max_q),
    .vl    (reg_vl)
  );

  vlo_next u_next (
    .dec     (dec),
    .bad_src (bad_src),
    .cur_vl  (vl_q),
    .cur_max (max_q),
    .reg_vl  (reg_vl),
    .nxt_vl  (nxt_vl),
    .nxt_max (nxt_max),
    .update  (update)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q     <= RST_VL;
      max_q    <= RST_MAXVL;
      wb_q     <= 1'b0;
      ill_q    <= 1'b0;
      wb_idx_q <= '0;
    end else begin
      wb_q  <= 1'b0;
      ill_q <= 1'b0;
      if (op_valid) begin
        ill_q <= bad_src;
        if (update) begin
          vl_q  <= nxt_vl;
          max_q <= nxt_max;
          if (dec.dest != '0) begin
            wb_q     <= 1'b1;
            wb_idx_q <= dec.dest;
          end
        end
      end
    end
  end

  assign src_idx    = dec.val;
  assign ovr_state  = {vl_q, max_q};
  assign wb_valid   = wb_q;
  assign wb_idx     = wb_idx_q;
  assign wb_data    = wb_q ? XLEN'(vl_q) : '0;
  assign illegal_op = ill_q;
endmodule

// File: rtl/vlo_checker.sv
module vlo_checker
  import vlo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_valid,
  input logic [FIELD_W-1:0]   vl_field,
  input logic [2*LEN_W-1:0]   ovr_state,
  input logic                 wb_valid,
  input logic [IDX_W-1:0]     wb_idx,
  input logic                 illegal_op
);
  p_zero_field_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && vl_field == '0 |=> $stable(ovr_state) && !wb_valid && !illegal_op);

  p_imm_vl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && vl_field != '0 && !vl_field[11] && !vl_field[0]
    |=> ovr_state[11:6] == LEN_W'($past(vl_field[5:1])) + LEN_W'(1)
        && $stable(ovr_state[5:0]));

  p_x0_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !vl_field[11] && vl_field[0] && vl_field[5:1] == '0
    |=> illegal_op && !wb_valid && $stable(ovr_state));

  p_reg_vl_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !vl_field[11] && vl_field[0] && vl_field[5:1] != '0
    |=> ovr_state[11:6] != '0 && ovr_state[11:6] <= ovr_state[5:0]);

  p_maxvl_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && vl_field[11]
    |=> ovr_state[5:0] == LEN_W'($past(vl_field[5:1])) + LEN_W'(1)
        && ovr_state[11:6] <= ovr_state[5:0]);

  p_no_wb_to_x0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && vl_field[10:6] == '0 |=> !wb_valid);

  p_wb_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && vl_field != '0 && vl_field[10:6] != '0 && !illegal_op
    && !(!vl_field[11] && vl_field[0] && vl_field[5:1] == '0)
    |=> wb_valid && wb_idx == $past(vl_field[10:6]));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !wb_valid && !illegal_op && $stable(ovr_state));
endmodule

bind vl_override_unit vlo_checker #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .vl_field   (vl_field),
  .ovr_state  (ovr_state),
  .wb_valid   (wb_valid),
  .wb_idx     (wb_idx),
  .illegal_op (illegal_op)
);

// File: tb/vl_override_unit_tb_top.sv
module vl_override_unit_tb_top;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            op_valid = 1'b0;
  logic [11:0]     vl_field = '0;
  logic [4:0]      src_idx;
  logic [XLEN-1:0] src_data = '0;
  logic [11:0]     ovr_state;
  logic            wb_valid;
  logic [4:0]      wb_idx;
  logic [XLEN-1:0] wb_data;
  logic            illegal_op;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int              m_vl = 1, m_max = 1;
  bit              m_wbv = 0, m_ill = 0;
  int              m_wbi = 0;
  string           m_tag = "R1";

  always #10 clk = ~clk;

  vl_override_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .vl_field(vl_field),
    .src_idx(src_idx), .src_data(src_data), .ovr_state(ovr_state),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .illegal_op(illegal_op)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk({"R9/", m_tag, " state"}, 64'(ovr_state), 64'({m_vl[5:0], m_max[5:0]}));
    chk({"R4/", m_tag, " illegal"}, 64'(illegal_op), 64'(m_ill));
    chk({"R8/", m_tag, " wb_valid"}, 64'(wb_valid), 64'(m_wbv));
    if (m_wbv) begin
      chk("R8 wb_idx", 64'(wb_idx), 64'(m_wbi));
      chk("R8 wb_data", wb_data, 64'(m_vl));
    end
  endtask

  task automatic model(input bit v, input logic [11:0] f, input logic [63:0] rs);
    int imm, nvl;
    bit upd;
    m_wbv = 0; m_ill = 0; upd = 0; nvl = m_vl;
    imm = int'(f[5:1]);
    if (!v) begin
      m_tag = "R10";
      return;
    end
    if (f == 12'd0) begin
      m_tag = "R2";
    end else if (!f[11] && !f[0]) begin
      m_tag = "R3"; nvl = imm + 1; upd = 1;
    end else if (!f[11]) begin
      if (imm == 0) begin
        m_tag = "R4"; m_ill = 1;
      end else begin
        m_tag = "R5"; upd = 1;
        if (rs == 0) nvl = 1;
        else if (rs > 64'(m_max)) nvl = m_max;
        else nvl = int'(rs);
      end
    end else if (!f[0]) begin
      m_tag = "R6"; m_max = imm + 1; nvl = imm + 1; upd = 1;
    end else begin
      m_tag = "R7"; m_max = imm + 1;
      nvl = (m_vl > m_max) ? m_max : m_vl; upd = 1;
    end
    if (upd) begin
      m_vl = nvl;
      if (f[10:6] != 0) begin
        m_wbv = 1; m_wbi = int'(f[10:6]);
      end
    end
  endtask

  task automatic cycle(input bit v, input logic [11:0] f, input logic [63:0] rs);
    @(negedge clk);
    compare();
    op_valid = v; vl_field = f; src_data = rs;
    model(v, f, rs);
    #1;
    chk("R5 src_idx", 64'(src_idx), 64'(f[5:1]));
  endtask

  function automatic logic [11:0] enc(input bit m, input int dest, input int val, input bit s);
    return {m, 5'(dest), 5'(val), s};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state observed before any strobe
    cycle(0, 12'd0, 64'd0);
    cycle(1, 12'd0, 64'd0);                          // R2 zero field
    cycle(1, enc(0, 3, 4, 0), 64'd0);                // R3 VL=5 above MAXVL=1
    cycle(1, enc(0, 0, 0, 0) | 12'h040, 64'd0);      // R3 imm 0 -> VL=1, wb to x1
    cycle(1, enc(0, 3, 4, 0), 64'd0);                // R3 VL=5 again
    cycle(1, enc(1, 0, 2, 1), 64'd0);                // R7 MAXVL=3, VL clamps to 3, no wb
    cycle(1, enc(1, 9, 9, 1), 64'd0);                // R7 MAXVL=10, VL stays 3
    cycle(1, enc(0, 5, 0, 1), 64'd77);               // R4 x0 source
    cycle(0, 12'd0, 64'd0);                          // R10 idle
    cycle(1, enc(0, 6, 7, 1), 64'd0);                // R5 zero -> 1
    cycle(1, enc(0, 6, 7, 1), 64'd1000);             // R5 clamp to 10
    cycle(1, enc(0, 6, 7, 1), 64'd6);                // R5 in range
    cycle(1, enc(0, 6, 7, 1), 64'h8000_0000_0000_0004); // R5 high bits set
    cycle(1, enc(1, 31, 31, 0), 64'd0);              // R6 both 32
    cycle(1, enc(1, 2, 0, 0), 64'd0);                // R6 both 1
    cycle(0, 12'd0, 64'd0);                          // R10
    cycle(0, 12'd0, 64'd0);
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] f;
      logic [63:0] rs;
      bit v;
      v = ($urandom % 10) < 7;
      f = 12'($urandom);
      if ($urandom % 8 == 0) f = 12'd0;
      if ($urandom % 2 == 0) rs = 64'($urandom % 70);
      else rs = {32'($urandom), 32'($urandom)};
      cycle(v, f, rs);
    end
    cycle(0, 12'd0, 64'd0);
    @(negedge clk);
    compare();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule